// File: doc/BRIEF.md
# Nibble Port-Expander Bus Sequencer

This block runs one transfer to an external 4-bit I/O expander over the low nibble of an 8-bit port, with a separate active-low strobe. A host hands it a request that names an operation (read, write, OR-write, AND-write), a 2-bit expander port number and a 4-bit data nibble. The sequencer then steps through two consecutive machine cycles. Each machine cycle has five states, and an external timing source supplies the current state and a flag that marks the second cycle. The sequencer first places a command nibble on the port. It then places either the data nibble (for the write variants) or all ones (for a read, so that the expander can drive the pins). The strobe frames the whole exchange.

Requests use a valid/ready handshake. Ready is high only when the sequencer is idle and the timing source is in state 1 of a first machine cycle. A request held across other states simply waits, because the handshake completes only when valid and ready are both high. The read response is a valid-only stream with no back-pressure. The bus fixes the sample time, so the consumer must take the one-clock pulse when it arrives, and the data stays on the output until the next read.

Top module: `nibx_sequencer`

## Requirements
- R1: `req_ready` is high only while the sequencer is idle, `mstate` equals 1 and `second_cyc` is low. A request is taken when `req_valid` and `req_ready` are both high. `busy` is then high from the next clock until the strobe returns high, and `req_ready` stays low for that whole time.
- R2: In the clock that follows state 3 of the first cycle, `port_out` carries the command nibble. Bits 1:0 hold the port number and bits 3:2 hold the operation code: read 00, write 01, OR-write 10, AND-write 11.
- R3: `port_out[7:4]` is always zero, so expander traffic uses only the low nibble.
- R4: For write, OR-write and AND-write, `port_out[3:0]` holds the request's data nibble in the clocks that follow state 4 and state 5 of the first cycle and state 1 of the second cycle.
- R5: For a read, `port_out[3:0]` is 1111 in those same three clocks, which releases the pins to act as inputs.
- R6: `prog_n` goes low in the clock after state 3 of the first cycle. It returns high in the clock after state 2 of the second cycle. It is high at all other times.
- R7: `port_oe` is high exactly while `prog_n` is low. `port_out` reads zero whenever `port_oe` is low.
- R8: For a read, `exp_in` is sampled in state 2 of the second cycle. `rsp_valid` is high for exactly one clock after that, and `rsp_data` equals the sampled nibble zero-extended to 8 bits. Write variants never raise `rsp_valid`.
- R9: A synchronous reset, `rst` high at a clock edge, returns the sequencer to idle with `prog_n` high and `port_oe`, `busy` and `rsp_valid` low, even in the middle of a transfer.
- R10: A request presented while `req_ready` is low is ignored. `busy`, `port_oe` and `prog_n` stay at their idle values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mstate | input | 3 | Current machine state, binary 1 to 5 (one-hot, 5 bits, when MST_ONEHOT is set) |
| second_cyc | input | 1 | High during the second machine cycle of a pair |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this clock |
| req_op | input | 2 | Operation code: 00 read, 01 write, 10 OR-write, 11 AND-write |
| req_sel | input | 2 | Expander port number |
| req_nib | input | 4 | Data nibble for the write variants |
| exp_in | input | 4 | Low-nibble pin levels read back from the port |
| port_out | output | 8 | Port drive value |
| port_oe | output | 1 | Port drive enable |
| prog_n | output | 1 | Expander strobe, active low |
| busy | output | 1 | Transfer in progress |
| rsp_valid | output | 1 | One-clock pulse carrying read data |
| rsp_data | output | 8 | Read nibble, zero-extended |

## Verification
Directed transfers cover every operation code with the lowest and highest port numbers and data nibbles of 0000 and 1111. These tell apart swapped opcode or port fields and confusion between the read release value and a real data nibble. Random transfers, seeded once, then mix all the fields. During these transfers the pins read back a different nibble in every state except state 2 of the second cycle, so a sample taken one state early or late returns the wrong value. Stray requests in every non-accepting state, including state 1 of a second cycle, and a reset in the middle of a transfer show that the handshake window and the abort path are exact.

// File: rtl/nibx_pkg.sv
package nibx_pkg;
  localparam int NIB_W   = 4;
  localparam int SEL_W   = 2;
  localparam int OPC_W   = 2;
  localparam int PORT_W  = 2 * NIB_W;
  localparam int NUM_MST = 5;

  typedef enum logic [OPC_W-1:0] {
    XOP_READ  = 2'b00,
    XOP_WRITE = 2'b01,
    XOP_OR    = 2'b10,
    XOP_AND   = 2'b11
  } xop_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FIRST  = 2'd1,
    PH_SECOND = 2'd2
  } phase_e;

  typedef struct packed {
    xop_e             op;
    logic [SEL_W-1:0] sel;
    logic [NIB_W-1:0] nib;
  } xreq_t;

  typedef struct packed {
    logic s1_first;
    logic s3_first;
    logic s4_first;
    logic s5_first;
    logic s2_second;
  } tstrobe_t;

  // command nibble: operation in the upper pair, port select in the lower pair
  function automatic logic [NIB_W-1:0] pack_cmd(xop_e op, logic [SEL_W-1:0] sel);
    return {op, sel};
  endfunction
endpackage

// File: rtl/nibx_timing.sv
module nibx_timing
  import nibx_pkg::*;
#(
  parameter bit MST_ONEHOT = 1'b0,
  parameter int MST_W      = 3
) (
  input  logic [MST_W-1:0] mstate,
  input  logic             second_cyc,
  output tstrobe_t         st
);
  logic [NUM_MST-1:0] hit;

  for (genvar k = 0; k < NUM_MST; k++) begin : g_hit
    if (MST_ONEHOT) begin : g_oh
      assign hit[k] = mstate[k];
    end else begin : g_bin
      assign hit[k] = (mstate == MST_W'(k + 1));
    end
  end

  always_comb begin
    st.s1_first  = hit[0] && !second_cyc;
    st.s3_first  = hit[2] && !second_cyc;
    st.s4_first  = hit[3] && !second_cyc;
    st.s5_first  = hit[4] && !second_cyc;
    st.s2_second = hit[1] &&  second_cyc;
  end
endmodule

// File: rtl/nibx_phase_ctl.sv
module nibx_phase_ctl
  import nibx_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  tstrobe_t st,
  input  logic     req_valid,
  output logic     req_ready,
  output logic     accept,
  output logic     load_cmd,
  output logic     load_data,
  output logic     release_bus,
  output logic     busy
);
  phase_e ph_q;

  assign req_ready   = (ph_q == PH_IDLE) && st.s1_first;
  assign accept      = req_ready && req_valid;
  assign load_cmd    = (ph_q == PH_FIRST) && st.s3_first;
  assign load_data   = (ph_q == PH_FIRST) && st.s4_first;
  assign release_bus = (ph_q == PH_SECOND) && st.s2_second;
  assign busy        = (ph_q != PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q <= PH_IDLE;
    end else begin
      unique case (ph_q)
        PH_IDLE:   if (accept)      ph_q <= PH_FIRST;
        PH_FIRST:  if (st.s5_first) ph_q <= PH_SECOND;
        PH_SECOND: if (release_bus) ph_q <= PH_IDLE;
        default:                    ph_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nibx_port_drv.sv
module nibx_port_drv
  import nibx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  xreq_t             req,
  input  logic              load_cmd,
  input  logic              load_data,
  input  logic              release_bus,
  input  logic [NIB_W-1:0]  exp_in,
  output logic [PORT_W-1:0] port_out,
  output logic              port_oe,
  output logic              prog_n,
  output logic              rsp_valid,
  output logic [PORT_W-1:0] rsp_data
);
  localparam int HI_W = PORT_W - NIB_W;

  xreq_t            held_q;
  logic [NIB_W-1:0] lat_q;
  logic [NIB_W-1:0] cap_q;
  logic             oe_q;
  logic             prog_n_q;
  logic             rv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q   <= '0;
      lat_q    <= '0;
      cap_q    <= '0;
      oe_q     <= 1'b0;
      prog_n_q <= 1'b1;
      rv_q     <= 1'b0;
    end else begin
      rv_q <= 1'b0;
      if (accept) held_q <= req;
      if (load_cmd) begin
        lat_q    <= pack_cmd(held_q.op, held_q.sel);
        oe_q     <= 1'b1;
        prog_n_q <= 1'b0;
      end
      if (load_data) begin
        lat_q <= (held_q.op == XOP_READ) ? {NIB_W{1'b1}} : held_q.nib;
      end
      if (release_bus) begin
        oe_q     <= 1'b0;
        prog_n_q <= 1'b1;
        if (held_q.op == XOP_READ) begin
          rv_q  <= 1'b1;
          cap_q <= exp_in;
        end
      end
    end
  end

  assign port_out  = oe_q ? {{HI_W{1'b0}}, lat_q} : '0;
  assign port_oe   = oe_q;
  assign prog_n    = prog_n_q;
  assign rsp_valid = rv_q;
  assign rsp_data  = {{HI_W{1'b0}}, cap_q};
endmodule

// File: rtl/nibx_sequencer.sv
module nibx_sequencer
  import nibx_pkg::*;
#(
  parameter bit MST_ONEHOT = 1'b0,
  localparam int MST_W     = MST_ONEHOT ? NUM_MST : 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MST_W-1:0]  mstate,
  input  logic              second_cyc,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [OPC_W-1:0]  req_op,
  input  logic [SEL_W-1:0]  req_sel,
  input  logic [NIB_W-1:0]  req_nib,
  input  logic [NIB_W-1:0]  exp_in,
  output logic [PORT_W-1:0] port_out,
  output logic              port_oe,
  output logic              prog_n,
  output logic              busy,
  output logic              rsp_valid,
  output logic [PORT_W-1:0] rsp_data
);
  tstrobe_t st;
  xreq_t    req;
  logic     accept, load_cmd, load_data, release_bus;

  assign req.op  = xop_e'(req_op);
  assign req.sel = req_sel;
  assign req.nib = req_nib;

  nibx_timing #(.MST_ONEHOT(MST_ONEHOT), .MST_W(MST_W)) u_timing (
    .mstate     (mstate),
    .second_cyc (second_cyc),
    .st         (st)
  );

  nibx_phase_ctl u_phase (
    .clk         (clk),
    .rst         (rst),
    .st          (st),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .accept      (accept),
    .load_cmd    (load_cmd),
    .load_data   (load_data),
    .release_bus (release_bus),
    .busy        (busy)
  );

  nibx_port_drv u_drv (
    .clk         (clk),
    .rst         (rst),
    .accept      (accept),
    .req         (req),
    .load_cmd    (load_cmd),
    .load_data   (load_data),
    .release_bus (release_bus),
    .exp_in      (exp_in),
    .port_out    (port_out),
    .port_oe     (port_oe),
    .prog_n      (prog_n),
    .rsp_valid   (rsp_valid),
    .rsp_data    (rsp_data)
  );
endmodule

// File: rtl/nibx_sequencer_chk.sv
module nibx_sequencer_chk
  import nibx_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [PORT_W-1:0] port_out,
  input logic              port_oe,
  input logic              prog_n,
  input logic              busy,
  input logic              rsp_valid
);
  // R1
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> busy);

  // R1
  busy_blocks_ready_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !req_ready);

  // R3
  upper_nibble_zero_chk: assert property (@(posedge clk) disable iff (rst)
    port_out[PORT_W-1:NIB_W] == '0);

  // R6
  strobe_within_busy_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(prog_n) |-> busy);

  // R7
  strobe_implies_drive_chk: assert property (@(posedge clk) disable iff (rst)
    !prog_n |-> port_oe);

  // R7
  drive_implies_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    port_oe |-> !prog_n);

  // R8
  rsp_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R8
  rsp_at_strobe_end_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $rose(prog_n));

  // R9
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (prog_n && !port_oe && !busy && !rsp_valid));
endmodule

bind nibx_sequencer nibx_sequencer_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .port_out  (port_out),
  .port_oe   (port_oe),
  .prog_n    (prog_n),
  .busy      (busy),
  .rsp_valid (rsp_valid)
);

// File: tb/nibx_sequencer_test.sv
module nibx_sequencer_test;
  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] mstate;
  logic       second_cyc;
  logic       req_valid;
  logic       req_ready;
  logic [1:0] req_op;
  logic [1:0] req_sel;
  logic [3:0] req_nib;
  logic [3:0] exp_in;
  logic [7:0] port_out;
  logic       port_oe;
  logic       prog_n;
  logic       busy;
  logic       rsp_valid;
  logic [7:0] rsp_data;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  nibx_sequencer uut (
    .clk(clk), .rst(rst), .mstate(mstate), .second_cyc(second_cyc),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_sel(req_sel), .req_nib(req_nib), .exp_in(exp_in),
    .port_out(port_out), .port_oe(port_oe), .prog_n(prog_n), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  function automatic logic [7:0] exp_cmd(logic [1:0] op, logic [1:0] sel);
    return {4'b0000, op, sel};
  endfunction

  function automatic logic [7:0] exp_drive(logic [1:0] op, logic [3:0] nib);
    return (op == 2'b00) ? 8'h0F : {4'b0000, nib};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic tick(logic [2:0] s, logic sec);
    mstate = s;
    second_cyc = sec;
    @(posedge clk);
    #1;
  endtask

  task automatic check_idle(string tag);
    chk(tag, busy, 0, "busy idle");
    chk(tag, port_oe, 0, "oe idle");
    chk(tag, prog_n, 1, "prog idle");
    chk(tag, port_out, 0, "port idle");
  endtask

  task automatic xfer(logic [1:0] op, logic [1:0] sel, logic [3:0] nib, logic [3:0] rd);
    exp_in = ~rd;
    mstate = 3'd1; second_cyc = 1'b0;
    req_valid = 1'b1; req_op = op; req_sel = sel; req_nib = nib;
    #1;
    chk("R1", req_ready, 1, "ready in state 1 first");
    @(posedge clk); #1;
    req_valid = 1'b0;
    req_op = ~op; req_sel = ~sel; req_nib = ~nib;
    chk("R1", busy, 1, "busy after accept");
    chk("R7", port_oe, 0, "no drive before command");
    tick(3'd2, 1'b0);
    chk("R6", prog_n, 1, "strobe high before state 4");
    tick(3'd3, 1'b0);
    chk("R2", port_out, exp_cmd(op, sel), "command nibble");
    chk("R6", prog_n, 0, "strobe low at state 4");
    chk("R7", port_oe, 1, "drive on at state 4");
    chk("R3", port_out[7:4], 0, "upper nibble");
    tick(3'd4, 1'b0);
    chk((op == 2'b00) ? "R5" : "R4", port_out, exp_drive(op, nib), "data phase s5");
    tick(3'd5, 1'b0);
    chk((op == 2'b00) ? "R5" : "R4", port_out, exp_drive(op, nib), "data phase s1b");
    req_valid = 1'b1;
    mstate = 3'd1; second_cyc = 1'b1;
    #1;
    chk("R1", req_ready, 0, "no ready while busy");
    @(posedge clk); #1;
    req_valid = 1'b0;
    chk((op == 2'b00) ? "R5" : "R4", port_out, exp_drive(op, nib), "data phase s2b");
    chk("R6", prog_n, 0, "strobe held in second cycle");
    exp_in = rd;
    tick(3'd2, 1'b1);
    exp_in = ~rd;
    chk("R6", prog_n, 1, "strobe released");
    chk("R7", port_oe, 0, "drive released");
    chk("R7", port_out, 0, "port quiet");
    chk("R1", busy, 0, "busy ends");
    chk("R8", rsp_valid, (op == 2'b00), "response pulse");
    if (op == 2'b00) chk("R8", rsp_data, {4'b0000, rd}, "read nibble");
    tick(3'd3, 1'b1);
    chk("R8", rsp_valid, 0, "pulse one clock");
    tick(3'd4, 1'b1);
    tick(3'd5, 1'b1);
  endtask

  task automatic stray_pair();
    req_op = 2'b01; req_sel = 2'b10; req_nib = 4'h5;
    for (int sec = 0; sec < 2; sec++) begin
      for (int s = 1; s <= 5; s++) begin
        req_valid = !(sec == 0 && s == 1);
        mstate = 3'(s); second_cyc = sec[0];
        #1;
        if (req_valid) chk("R10", req_ready, 0, "stray not ready");
        @(posedge clk); #1;
        check_idle("R10");
      end
    end
    req_valid = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed0;
    seed0 = $urandom(32'h1A2B);
    rst = 1'b1; req_valid = 1'b0; req_op = '0; req_sel = '0; req_nib = '0;
    exp_in = '0; mstate = 3'd1; second_cyc = 1'b0;
    tick(3'd1, 1'b0);
    tick(3'd2, 1'b0);
    check_idle("R9");
    chk("R9", rsp_valid, 0, "no response in reset");
    rst = 1'b0;
    tick(3'd3, 1'b0); tick(3'd4, 1'b0); tick(3'd5, 1'b0);
    for (int s = 1; s <= 5; s++) tick(3'(s), 1'b1);

    // directed corners
    for (int op = 0; op < 4; op++) begin
      xfer(2'(op), 2'b00, 4'h0, 4'hA);
      xfer(2'(op), 2'b11, 4'hF, 4'h5);
    end
    stray_pair();

    // reset mid-transfer
    mstate = 3'd1; second_cyc = 1'b0; req_valid = 1'b1; req_op = 2'b00;
    req_sel = 2'b01; req_nib = 4'h3;
    @(posedge clk); #1;
    req_valid = 1'b0;
    tick(3'd2, 1'b0); tick(3'd3, 1'b0); tick(3'd4, 1'b0);
    rst = 1'b1;
    tick(3'd5, 1'b0);
    rst = 1'b0;
    check_idle("R9");
    for (int s = 1; s <= 5; s++) begin
      exp_in = 4'h9;
      tick(3'(s), 1'b1);
      check_idle("R9");
      chk("R9", rsp_valid, 0, "no response after abort");
    end

    // random transfers
    for (int i = 0; i < 40; i++) begin
      xfer(2'($urandom), 2'($urandom), 4'($urandom), 4'($urandom));
      if ($urandom_range(0, 3) == 0) stray_pair();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule